// File: doc/BRIEF.md
# User-Level Register Window

This block is a small memory-mapped register slave that answers a 64 KB window intended to be mapped straight into user-level software. It offers three kinds of registers: a fixed read-only identifier, a pair of read-only words that together expose a free-running time value kept in 32 ns units, and a write-only doorbell that hands a written channel number to a downstream scheduler as a one-cycle pulse.

Requests arrive on a single-cycle interface: a valid strobe, a write flag, a 16-bit byte offset and 32-bit write data. Read results come back registered, one cycle later, with a read-valid strobe. Offsets the block does not define never produce an error of any kind: reads of them return zero and writes to them vanish.

The internal time value is 61 bits wide, but its five least significant bits are always zero, so the block keeps a 56-bit count of 32 ns units. A tick-enable input advances the count by one unit per cycle, and a synchronous load port replaces it outright.

Top module: `user_reg_window`

## Requirements
- R1: After reset, rdValid and bellValid are low, rdData is zero and the time count is zero.
- R2: A read request (reqValid high, reqWrite low) makes rdValid high in the next cycle only; in any cycle with rdValid low, rdData is zero.
- R3: A read at offset 0x0000 returns 0x0000C361 (identifier 50017 in bits 15:0, upper bits zero).
- R4: A read at offset 0x0080 returns count bits 26:0 in rdData bits 31:5, with bits 4:0 zero; the value is the count as it stood in the request cycle.
- R5: A read at offset 0x0084 returns count bits 55:27 in rdData bits 28:0, with bits 31:29 zero.
- R6: In each cycle with tickEn high and loadEn low, the count grows by one unit (32 ns of time value) and wraps to zero after its all-ones value.
- R7: In a cycle with loadEn high, the count takes loadValue (a value in 32 ns units), and the load wins over a tick in the same cycle.
- R8: A write at offset 0x0090 raises bellValid for exactly the next cycle with bellId equal to the written data.
- R9: Reads of every other offset (0x0004 to 0x007F, 0x0088, 0x008C, 0x0090 and all unlisted offsets) return zero; writes to any offset other than 0x0090 raise no doorbell and leave the identifier and time count unchanged.
- R10: All 16 offset bits are decoded exactly, so an offset such as 0x0081 or 0x0092 is undefined and behaves as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, one access per high cycle |
| reqWrite | input | 1 | High for a write, low for a read |
| reqAddr | input | 16 | Byte offset within the window |
| reqWdata | input | 32 | Write data |
| rdValid | output | 1 | Read data valid, one cycle after a read request |
| rdData | output | 32 | Registered read data, zero when rdValid is low |
| tickEn | input | 1 | Advance the time count by one 32 ns unit |
| loadEn | input | 1 | Load the time count from loadValue |
| loadValue | input | 56 | New time count in 32 ns units |
| bellValid | output | 1 | Doorbell pulse |
| bellId | output | 32 | Channel number carried by the doorbell |

## Verification
Both the read result and the doorbell pulse are due exactly one clock after the request that causes them, and a read returns the count as it stood before that same edge's tick or load takes effect. The bench changes inputs on the falling edge, advances its own model of the count at the rising edge only after computing the expected read word from the pre-edge count, and compares outputs at the following falling edge. Each request is therefore matched against its own response, with no cycle skew between stimulus and check.

// File: rtl/urw_pkg.sv
package urw_pkg;

  // Offsets with defined behaviour; all other offsets are undefined.
  localparam logic [15:0] OFS_CLASS   = 16'h0000;
  localparam logic [15:0] OFS_TIME_LO = 16'h0080;
  localparam logic [15:0] OFS_TIME_HI = 16'h0084;
  localparam logic [15:0] OFS_BELL    = 16'h0090;

  localparam logic [15:0] CLASS_VALUE = 16'd50017;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic rdEn;
    logic selClass;
    logic selTimeLo;
    logic selTimeHi;
    logic bellWr;
  } urw_strobe_t;

endpackage

// File: rtl/urw_ctrl.sv
module urw_ctrl
  import urw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output urw_strobe_t       strobes
);

  logic isRead;
  logic isWrite;
  logic hitClass;
  logic hitLo;
  logic hitHi;
  logic hitBell;

  always_comb begin
    isRead   = reqValid && !reqWrite;
    isWrite  = reqValid && reqWrite;
    hitClass = (reqAddr == ADDR_W'(OFS_CLASS));
    hitLo    = (reqAddr == ADDR_W'(OFS_TIME_LO));
    hitHi    = (reqAddr == ADDR_W'(OFS_TIME_HI));
    hitBell  = (reqAddr == ADDR_W'(OFS_BELL));

    strobes.rdEn      = isRead;
    strobes.selClass  = isRead && hitClass;
    strobes.selTimeLo = isRead && hitLo;
    strobes.selTimeHi = isRead && hitHi;
    strobes.bellWr    = isWrite && hitBell;
  end

endmodule

// File: rtl/urw_timecount.sv
module urw_timecount #(
  parameter int CNT_W = 56
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             loadEn,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (loadEn) begin
      count <= loadValue;
    end else if (tickEn) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/urw_datapath.sv
module urw_datapath
  import urw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 56,
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  urw_strobe_t       strobes,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [CNT_W-1:0]  count,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              bellValid,
  output logic [DATA_W-1:0] bellId
);

  localparam int LO_W = DATA_W - FRAC_W;
  localparam int HI_W = CNT_W - LO_W;

  logic [DATA_W-1:0] wordClass;
  logic [DATA_W-1:0] wordLo;
  logic [DATA_W-1:0] wordHi;
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    wordClass = DATA_W'(CLASS_VALUE);
    wordLo    = {count[LO_W-1:0], {FRAC_W{1'b0}}};
    wordHi    = DATA_W'(count[CNT_W-1:LO_W]);
    rdNext    = '0;
    if (strobes.selClass)  rdNext = wordClass;
    if (strobes.selTimeLo) rdNext = wordLo;
    if (strobes.selTimeHi) rdNext = wordHi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.rdEn;
      rdData  <= strobes.rdEn ? rdNext : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bellValid <= 1'b0;
      bellId    <= '0;
    end else begin
      bellValid <= strobes.bellWr;
      if (strobes.bellWr) bellId <= reqWdata;
    end
  end

  if (HI_W > DATA_W) begin : g_bad_width
    initial $error("time count high part wider than data word");
  end

endmodule

// File: rtl/user_reg_window.sv
module user_reg_window
  import urw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TIME_W = 61,
  parameter int FRAC_W = 5,
  localparam int CNT_W = TIME_W - FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  input  logic              tickEn,
  input  logic              loadEn,
  input  logic [CNT_W-1:0]  loadValue,
  output logic              bellValid,
  output logic [DATA_W-1:0] bellId
);

  urw_strobe_t      strobes;
  logic [CNT_W-1:0] count;

  urw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .strobes  (strobes)
  );

  urw_timecount #(.CNT_W(CNT_W)) u_time (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .loadEn    (loadEn),
    .loadValue (loadValue),
    .count     (count)
  );

  urw_datapath #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .FRAC_W (FRAC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqWdata  (reqWdata),
    .count     (count),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .bellValid (bellValid),
    .bellId    (bellId)
  );

endmodule

// File: rtl/user_reg_window_chk.sv
module user_reg_window_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [15:0] reqAddr,
  input logic [31:0] reqWdata,
  input logic        rdValid,
  input logic [31:0] rdData,
  input logic        bellValid,
  input logic [31:0] bellId
);

  logic rdReq;
  logic bellReq;
  logic undefRd;

  assign rdReq   = reqValid && !reqWrite;
  assign bellReq = reqValid && reqWrite && (reqAddr == 16'h0090);
  assign undefRd = rdReq && (reqAddr != 16'h0000) && (reqAddr != 16'h0080)
                   && (reqAddr != 16'h0084);

  p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rdValid);

  p_rd_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> (!rdValid && rdData == 32'h0));

  p_class_word_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && reqAddr == 16'h0000) |=> (rdData == 32'h0000C361));

  p_lo_gran_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && reqAddr == 16'h0080) |=> (rdData[4:0] == 5'h0));

  p_hi_top_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && reqAddr == 16'h0084) |=> (rdData[31:29] == 3'h0));

  p_bell_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    bellReq |=> (bellValid && bellId == $past(reqWdata)));

  p_no_bell_r9: assert property (@(posedge clk) disable iff (!rstN)
    !bellReq |=> !bellValid);

  p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    undefRd |=> (rdData == 32'h0));

endmodule

bind user_reg_window user_reg_window_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .reqAddr   (reqAddr),
  .reqWdata  (reqWdata),
  .rdValid   (rdValid),
  .rdData    (rdData),
  .bellValid (bellValid),
  .bellId    (bellId)
);

// File: tb/user_reg_window_tb.sv
module user_reg_window_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        tickEn = 1'b0;
  logic        loadEn = 1'b0;
  logic [55:0] loadValue = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic        bellValid;
  logic [31:0] bellId;

  int total = 0;
  int bad = 0;
  logic [55:0] mCnt = '0;

  always #4 clk = ~clk;

  user_reg_window u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .tickEn    (tickEn),
    .loadEn    (loadEn),
    .loadValue (loadValue),
    .bellValid (bellValid),
    .bellId    (bellId)
  );

  function automatic logic [31:0] expRead(input logic [15:0] a, input logic [55:0] c);
    case (a)
      16'h0000: return 32'd50017;
      16'h0080: return {c[26:0], 5'b0};
      16'h0084: return {3'b0, c[55:27]};
      default:  return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic w, input logic [15:0] a);
    if (w) return (a == 16'h0090) ? "R8" : "R9";
    if (a == 16'h0000) return "R3";
    if (a == 16'h0080) return "R4";
    if (a == 16'h0084) return "R5";
    if (a[1:0] != 2'b00) return "R10";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, model at rising edge, check next falling edge.
  task automatic step(input logic v, input logic w, input logic [15:0] a,
                      input logic [31:0] d, input logic tk, input logic ld,
                      input logic [55:0] lv, input string tagIn);
    logic        eRdV;
    logic [31:0] eRd;
    logic        eBell;
    string       tag;
    reqValid = v; reqWrite = w; reqAddr = a; reqWdata = d;
    tickEn = tk; loadEn = ld; loadValue = lv;
    @(posedge clk);
    eRdV  = v && !w;
    eRd   = eRdV ? expRead(a, mCnt) : 32'h0;
    eBell = v && w && (a == 16'h0090);
    if (ld) mCnt = lv;
    else if (tk) mCnt = mCnt + 56'd1;
    @(negedge clk);
    tag = (tagIn == "") ? tagFor(w, a) : tagIn;
    check("R2", 32'(rdValid), 32'(eRdV));
    check(v ? tag : "R2", rdData, eRd);
    check(eBell ? "R8" : "R9", 32'(bellValid), 32'(eBell));
    if (eBell) check("R8", bellId, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd7319);
    repeat (3) @(negedge clk);
    // R1: outputs held at their reset values
    check("R1", 32'(rdValid), 32'h0);
    check("R1", rdData, 32'h0);
    check("R1", 32'(bellValid), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: count starts at zero
    step(1, 0, 16'h0080, 0, 0, 0, 0, "R1");
    step(1, 0, 16'h0084, 0, 0, 0, 0, "R1");
    // R3 identifier
    step(1, 0, 16'h0000, 0, 0, 0, 0, "R3");
    // R6: ticks then read
    step(0, 0, 16'h0, 0, 1, 0, 0, "R6");
    step(0, 0, 16'h0, 0, 1, 0, 0, "R6");
    step(1, 0, 16'h0080, 0, 0, 0, 0, "R6");
    // R6 wrap from all ones
    step(0, 0, 16'h0, 0, 0, 1, {56{1'b1}}, "R7");
    step(1, 0, 16'h0084, 0, 1, 0, 0, "R6");
    step(1, 0, 16'h0080, 0, 0, 0, 0, "R6");
    step(1, 0, 16'h0084, 0, 0, 0, 0, "R6");
    // R7: load wins over tick
    step(0, 0, 16'h0, 0, 1, 1, 56'h00_0000_0800_0005, "R7");
    step(1, 0, 16'h0080, 0, 0, 0, 0, "R7");
    step(1, 0, 16'h0084, 0, 0, 0, 0, "R7");
    // R9: writes to read-only registers change nothing
    step(1, 1, 16'h0080, 32'hFFFF_FFFF, 0, 0, 0, "R9");
    step(1, 1, 16'h0000, 32'h1234_5678, 0, 0, 0, "R9");
    step(1, 0, 16'h0080, 0, 0, 0, 0, "R9");
    step(1, 0, 16'h0000, 0, 0, 0, 0, "R9");
    // R8 doorbell, back to back, and read of doorbell offset
    step(1, 1, 16'h0090, 32'hDEAD_0042, 0, 0, 0, "R8");
    step(1, 1, 16'h0090, 32'h0000_0007, 0, 0, 0, "R8");
    step(1, 0, 16'h0090, 0, 0, 0, 0, "R9");
    // R10: near-miss offsets
    step(1, 0, 16'h0081, 0, 0, 0, 0, "R10");
    step(1, 1, 16'h0092, 32'h55, 0, 0, 0, "R10");
    step(1, 0, 16'h8080, 0, 0, 0, 0, "R10");
    step(1, 0, 16'h0088, 0, 0, 0, 0, "R9");
    step(1, 0, 16'h008C, 0, 0, 0, 0, "R9");

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [63:0] lv;
      case ($urandom % 10)
        0: a = 16'h0000;
        1: a = 16'h0004;
        2: a = 16'h007C;
        3: a = 16'h0080;
        4: a = 16'h0084;
        5: a = 16'h0088;
        6: a = 16'h008C;
        7: a = 16'h0090;
        8: a = 16'h0081;
        default: a = 16'($urandom);
      endcase
      lv = {$urandom, $urandom};
      step(($urandom % 4) != 0, ($urandom % 2) == 1, a, $urandom,
           ($urandom % 2) == 1, ($urandom % 64) == 0, lv[55:0], "");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule